// File: doc/BRIEF.md
# Wide Add/Subtract Engine with Shared Operand Memory

This block performs addition and subtraction on 1024-bit integers that live in an internal memory, under the control of a processor's multi-cycle custom-instruction port. The processor loads operands into the memory, and fetches results from it, through a narrow 32-bit host port. It then issues one instruction. The instruction carries only memory indices and an opcode, never operand data.

The engine reaches the same storage through its own full-width port. It reads the two sources, computes, and writes the full result to the destination index chosen by the host. After that it signals completion for one cycle. The instruction result word returns only the carry or borrow flag and an unsupported-opcode flag. The operand values never pass through the processor's data path.

Top module: `bn_engine`

## Requirements
- R1: While reset is high and right after it, `ci_done` is low, `host_rdata` reads zero, and the engine is idle.
- R2: Host word address `idx*32 + lane` selects 32-bit lane `lane` of wide word `idx`. Lane 0 holds the least significant bits. `host_rdata` shows the addressed lane one cycle after the address is applied, and `host_we` writes only that lane.
- R3: Instruction packing is as follows. `ci_dataa[15:0]` is the source-A index, `ci_dataa[31:16]` is the source-B index and `ci_datab[15:0]` is the destination index. Only the low log2(DEPTH) bits of each field are used.
- R4: Opcode 0 (add) writes (A + B) mod 2^1024 to the destination and returns the carry out in result bit 0.
- R5: Opcode 1 (subtract) writes (A − B) mod 2^1024 to the destination and returns a borrow in result bit 0. The borrow is 1 exactly when A < B.
- R6: Any other opcode writes no memory. It returns a result with bit 31 set and bit 0 clear, and completes with `ci_done` high in the cycle right after the start cycle.
- R7: For add and subtract, `ci_done` goes high four cycles after the cycle that follows the start cycle. It stays high for exactly one cycle, and result bits 30..1 are zero whenever `ci_done` is high.
- R8: A `ci_start` pulse that arrives while an instruction is in progress is ignored. It produces no completion and no memory write.
- R9: A destination equal to one of the sources gives the same result as a distinct destination, because both sources are read before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host lane write enable |
| host_addr | input | 8 | Host word address (wide index and lane) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle latency |
| ci_start | input | 1 | Instruction start pulse |
| ci_n | input | 8 | Opcode field |
| ci_dataa | input | 32 | Packed source-A and source-B indices |
| ci_datab | input | 32 | Packed destination index |
| ci_done | output | 1 | One-cycle completion strobe |
| ci_result | output | 32 | Bit 0 carry/borrow, bit 31 unsupported opcode |

## Verification
Each fault in the engine's internal state shows up at a specific point.

- **Sequencer.** A stuck or skipped state moves the completion strobe away from its fixed slot, or drops it entirely. The checker's cycle counter flags this on the very next edge, and the bench flags it when it compares completion times.
- **Carry chain or operand capture.** A wrong limb carry or a source captured on the wrong cycle shows no symptom at the instruction port until the destination is read back over the host port. The readback compares all 1024 bits.
- **Cross-limb carries.** The all-ones-plus-one and borrow cases force carries across every limb.
- **Busy handling.** The mid-flight start pulse exposes a sequencer that wrongly re-accepts an instruction. That failure appears as an extra completion, or as a changed word at an index that was never the target.

// File: rtl/bn_pkg.sv
package bn_pkg;

    localparam int CI_W  = 32;
    localparam int OPC_W = 8;
    localparam int FLD_W = 16;

    localparam logic [OPC_W-1:0] OPC_ADD = 8'd0;
    localparam logic [OPC_W-1:0] OPC_SUB = 8'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDA,
        ST_RDB,
        ST_CALC,
        ST_WR,
        ST_DONE
    } bn_state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [FLD_W-1:0] src_a;
        logic [FLD_W-1:0] src_b;
        logic [FLD_W-1:0] dst;
    } bn_cmd_t;

    function automatic bn_cmd_t unpack_cmd(input logic [OPC_W-1:0] n,
                                           input logic [CI_W-1:0] da,
                                           input logic [CI_W-1:0] db);
        bn_cmd_t c;
        c.opc   = n;
        c.src_a = da[FLD_W-1:0];
        c.src_b = da[CI_W-1:FLD_W];
        c.dst   = db[FLD_W-1:0];
        return c;
    endfunction

    function automatic logic op_supported(input logic [OPC_W-1:0] n);
        return (n == OPC_ADD) || (n == OPC_SUB);
    endfunction

    function automatic logic [CI_W-1:0] make_result(input logic unsup, input logic cb);
        return {unsup, {(CI_W-2){1'b0}}, cb};
    endfunction

endpackage

// File: rtl/bn_ram.sv
module bn_ram #(
    parameter int WIDE_W = 1024,
    parameter int HOST_W = 32,
    parameter int DEPTH  = 8,
    localparam int LANES  = WIDE_W / HOST_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int HA_W   = IDX_W + LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_we,
    input  logic [HA_W-1:0]   h_addr,
    input  logic [HOST_W-1:0] h_wdata,
    output logic [HOST_W-1:0] h_rdata,
    input  logic [IDX_W-1:0]  e_addr,
    input  logic              e_we,
    input  logic [WIDE_W-1:0] e_wdata,
    output logic [WIDE_W-1:0] e_rdata
);

    logic [WIDE_W-1:0] mem [DEPTH];

    logic [IDX_W-1:0]  h_idx;
    logic [LANE_W-1:0] h_lane;

    assign h_idx  = h_addr[HA_W-1:LANE_W];
    assign h_lane = h_addr[LANE_W-1:0];

    // Engine write is placed last so it takes precedence on a collision.
    always_ff @(posedge clk) begin
        if (h_we) begin
            mem[h_idx][int'(h_lane)*HOST_W +: HOST_W] <= h_wdata;
        end
        if (e_we) begin
            mem[e_addr] <= e_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rdata <= '0;
        end else begin
            h_rdata <= mem[h_idx][int'(h_lane)*HOST_W +: HOST_W];
        end
    end

    always_ff @(posedge clk) begin
        e_rdata <= mem[e_addr];
    end

endmodule

// File: rtl/bn_alu.sv
module bn_alu #(
    parameter int WIDE_W = 1024,
    parameter int LIMB_W = 32,
    localparam int NLIMB = WIDE_W / LIMB_W
) (
    input  logic [WIDE_W-1:0] a,
    input  logic [WIDE_W-1:0] b,
    input  logic              sub,
    output logic [WIDE_W-1:0] y,
    output logic              cb
);

    logic [NLIMB:0] carry;

    // Subtraction as a + ~b + 1: the chain's carry-in supplies the +1.
    assign carry[0] = sub;

    for (genvar g = 0; g < NLIMB; g++) begin : g_limb
        logic [LIMB_W:0] part;
        assign part = {1'b0, a[g*LIMB_W +: LIMB_W]}
                    + {1'b0, b[g*LIMB_W +: LIMB_W] ^ {LIMB_W{sub}}}
                    + {{LIMB_W{1'b0}}, carry[g]};
        assign y[g*LIMB_W +: LIMB_W] = part[LIMB_W-1:0];
        assign carry[g+1] = part[LIMB_W];
    end

    // A missing carry out of the top limb during subtraction means a borrow.
    assign cb = carry[NLIMB] ^ sub;

endmodule

// File: rtl/bn_ctrl.sv
module bn_ctrl
    import bn_pkg::*;
#(
    parameter int WIDE_W = 1024,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ci_start,
    input  logic [OPC_W-1:0]  ci_n,
    input  logic [CI_W-1:0]   ci_dataa,
    input  logic [CI_W-1:0]   ci_datab,
    output logic              ci_done,
    output logic [CI_W-1:0]   ci_result,
    output logic [IDX_W-1:0]  e_addr,
    output logic              e_we,
    output logic [WIDE_W-1:0] e_wdata,
    input  logic [WIDE_W-1:0] e_rdata,
    output logic [WIDE_W-1:0] alu_a,
    output logic [WIDE_W-1:0] alu_b,
    output logic              alu_sub,
    input  logic [WIDE_W-1:0] alu_y,
    input  logic              alu_cb
);

    bn_state_e         state;
    bn_cmd_t           cmd;
    logic [WIDE_W-1:0] opa;
    logic [WIDE_W-1:0] res;
    logic              res_cb;
    logic              unsup;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cmd    <= '0;
            opa    <= '0;
            res    <= '0;
            res_cb <= 1'b0;
            unsup  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ci_start) begin
                        cmd    <= unpack_cmd(ci_n, ci_dataa, ci_datab);
                        unsup  <= !op_supported(ci_n);
                        res_cb <= 1'b0;
                        state  <= op_supported(ci_n) ? ST_RDA : ST_DONE;
                    end
                end
                ST_RDA:  state <= ST_RDB;
                ST_RDB: begin
                    opa   <= e_rdata;
                    state <= ST_CALC;
                end
                ST_CALC: begin
                    res    <= alu_y;
                    res_cb <= alu_cb;
                    state  <= ST_WR;
                end
                ST_WR:   state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_RDB:  e_addr = cmd.src_b[IDX_W-1:0];
            ST_WR:   e_addr = cmd.dst[IDX_W-1:0];
            default: e_addr = cmd.src_a[IDX_W-1:0];
        endcase
    end

    assign e_we    = (state == ST_WR);
    assign e_wdata = res;

    assign alu_a   = opa;
    assign alu_b   = e_rdata;
    assign alu_sub = (cmd.opc == OPC_SUB);

    assign ci_done   = (state == ST_DONE);
    assign ci_result = ci_done ? make_result(unsup, res_cb) : '0;

    // Index bits above the memory depth and the upper half of datab carry no meaning.
    logic unused_hi;
    assign unused_hi = ^{cmd.src_a[FLD_W-1:IDX_W], cmd.src_b[FLD_W-1:IDX_W],
                         cmd.dst[FLD_W-1:IDX_W], ci_datab[CI_W-1:FLD_W]};

endmodule

// File: rtl/bn_engine.sv
module bn_engine
    import bn_pkg::*;
#(
    parameter int WIDE_W = 1024,
    parameter int HOST_W = 32,
    parameter int DEPTH  = 8,
    parameter int LIMB_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int HA_W  = IDX_W + $clog2(WIDE_W / HOST_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              ci_start,
    input  logic [OPC_W-1:0]  ci_n,
    input  logic [CI_W-1:0]   ci_dataa,
    input  logic [CI_W-1:0]   ci_datab,
    output logic              ci_done,
    output logic [CI_W-1:0]   ci_result
);

    logic [IDX_W-1:0]  eng_addr;
    logic              eng_we;
    logic [WIDE_W-1:0] eng_wdata;
    logic [WIDE_W-1:0] eng_rdata;
    logic [WIDE_W-1:0] alu_a;
    logic [WIDE_W-1:0] alu_b;
    logic              alu_sub;
    logic [WIDE_W-1:0] alu_y;
    logic              alu_cb;

    bn_ram #(.WIDE_W(WIDE_W), .HOST_W(HOST_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .h_we    (host_we),
        .h_addr  (host_addr),
        .h_wdata (host_wdata),
        .h_rdata (host_rdata),
        .e_addr  (eng_addr),
        .e_we    (eng_we),
        .e_wdata (eng_wdata),
        .e_rdata (eng_rdata)
    );

    bn_alu #(.WIDE_W(WIDE_W), .LIMB_W(LIMB_W)) u_alu (
        .a   (alu_a),
        .b   (alu_b),
        .sub (alu_sub),
        .y   (alu_y),
        .cb  (alu_cb)
    );

    bn_ctrl #(.WIDE_W(WIDE_W), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ci_start  (ci_start),
        .ci_n      (ci_n),
        .ci_dataa  (ci_dataa),
        .ci_datab  (ci_datab),
        .ci_done   (ci_done),
        .ci_result (ci_result),
        .e_addr    (eng_addr),
        .e_we      (eng_we),
        .e_wdata   (eng_wdata),
        .e_rdata   (eng_rdata),
        .alu_a     (alu_a),
        .alu_b     (alu_b),
        .alu_sub   (alu_sub),
        .alu_y     (alu_y),
        .alu_cb    (alu_cb)
    );

endmodule

// File: rtl/bn_engine_chk.sv
module bn_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        ci_start,
    input logic [7:0]  ci_n,
    input logic        ci_done,
    input logic [31:0] ci_result,
    input logic        eng_we
);

    logic       busy;
    logic [3:0] cnt;
    logic [3:0] lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            lat  <= '0;
        end else if (busy && ci_done) begin
            busy <= 1'b0;
        end else if (!busy && ci_start) begin
            busy <= 1'b1;
            cnt  <= '0;
            lat  <= (ci_n == 8'd0 || ci_n == 8'd1) ? 4'd4 : 4'd0;
        end else if (busy) begin
            cnt <= cnt + 4'd1;
        end
    end

    // R7, R8: completion only at the fixed slot after an accepted start
    p_done_slot_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ci_done == (cnt == lat)));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ci_done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        ci_done |=> !ci_done);

    p_result_zeros_r7: assert property (@(posedge clk) disable iff (rst)
        ci_done |-> (ci_result[30:1] == 30'd0));

    p_wr_then_done_r4: assert property (@(posedge clk) disable iff (rst)
        eng_we |=> ci_done);

    p_unsup_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && lat == 4'd0) |-> (!eng_we && ci_result[31] && !ci_result[0]));

    p_idle_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eng_we);

endmodule

bind bn_engine bn_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ci_start  (ci_start),
    .ci_n      (ci_n),
    .ci_done   (ci_done),
    .ci_result (ci_result),
    .eng_we    (eng_we)
);

// File: tb/bn_engine_tb.sv
module bn_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WIDE_W = 1024;
    localparam int HOST_W = 32;
    localparam int DEPTH  = 8;
    localparam int LANES  = WIDE_W / HOST_W;
    localparam int HA_W   = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              host_we;
    logic [HA_W-1:0]   host_addr;
    logic [HOST_W-1:0] host_wdata;
    logic [HOST_W-1:0] host_rdata;
    logic              ci_start;
    logic [7:0]        ci_n;
    logic [31:0]       ci_dataa;
    logic [31:0]       ci_datab;
    logic              ci_done;
    logic [31:0]       ci_result;

    bn_engine u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ci_start   (ci_start),
        .ci_n       (ci_n),
        .ci_dataa   (ci_dataa),
        .ci_datab   (ci_datab),
        .ci_done    (ci_done),
        .ci_result  (ci_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [31:0] res;
        int          due;
        string       tag;
    } exp_t;

    exp_t              sbq[$];
    logic [WIDE_W-1:0] model [DEPTH];
    int                n_chk  = 0;
    int                n_fail = 0;
    bit                finished = 1'b0;

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic checkw(input string tag, input logic [WIDE_W-1:0] act, input logic [WIDE_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: pops the scoreboard on every completion strobe
    always @(negedge clk) begin
        if (!rst && ci_done) begin
            if (sbq.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R8: unexpected completion, actual result %h expected none", ci_result);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check32({e.tag, " result"}, ci_result, e.res);
                check32({"R7 latency ", e.tag}, 32'(cyc), 32'(e.due));
            end
        end
    end

    task automatic hwrite(input int idx, input logic [WIDE_W-1:0] val);
        for (int l = 0; l < LANES; l++) begin
            @(negedge clk);
            host_we    = 1'b1;
            host_addr  = HA_W'(idx * LANES + l);
            host_wdata = val[l*HOST_W +: HOST_W];
        end
        @(negedge clk);
        host_we = 1'b0;
        model[idx] = val;
    endtask

    task automatic hread(input int idx, output logic [WIDE_W-1:0] val);
        @(negedge clk);
        host_addr = HA_W'(idx * LANES);
        for (int l = 0; l < LANES; l++) begin
            @(negedge clk);
            val[l*HOST_W +: HOST_W] = host_rdata;
            host_addr = HA_W'(idx * LANES + ((l + 1) % LANES));
        end
    endtask

    task automatic verify_word(input string tag, input int idx);
        logic [WIDE_W-1:0] v;
        hread(idx, v);
        checkw(tag, v, model[idx]);
    endtask

    // Driver: computes the expected outcome and pushes it into the scoreboard
    task automatic issue(input logic [7:0] n, input int a, input int b, input int d, input string tag);
        exp_t          e;
        logic [WIDE_W:0] t;
        bit            sup;
        @(negedge clk);
        sup = (n == 8'd0) || (n == 8'd1);
        ci_start = 1'b1;
        ci_n     = n;
        ci_dataa = {16'(b), 16'(a)};
        ci_datab = {16'h0, 16'(d)};
        e.tag = tag;
        e.due = cyc + 1 + (sup ? 4 : 0);
        if (n == 8'd0) begin
            t = {1'b0, model[a]} + {1'b0, model[b]};
            e.res = {31'd0, t[WIDE_W]};
            model[d] = t[WIDE_W-1:0];
        end else if (n == 8'd1) begin
            t = {1'b0, model[a]} - {1'b0, model[b]};
            e.res = {31'd0, t[WIDE_W]};
            model[d] = t[WIDE_W-1:0];
        end else begin
            e.res = 32'h8000_0000;
        end
        sbq.push_back(e);
        @(negedge clk);
        ci_start = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    function automatic logic [WIDE_W-1:0] rnd_wide();
        logic [WIDE_W-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst = 1'b1;
        host_we = 1'b0;
        host_addr = '0;
        host_wdata = '0;
        ci_start = 1'b0;
        ci_n = '0;
        ci_dataa = '0;
        ci_datab = '0;
        repeat (3) @(negedge clk);
        check32("R1 done in reset", {31'd0, ci_done}, 32'd0);
        check32("R1 rdata in reset", host_rdata, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check32("R1 done after reset", {31'd0, ci_done}, 32'd0);

        for (int i = 0; i < DEPTH; i++) hwrite(i, rnd_wide());
        verify_word("R2 host lane readback", 5);

        // R3, R4: random add with distinct indices in all three fields
        issue(8'd0, 0, 1, 2, "R4 add random");
        verify_word("R4 add dest", 2);

        // R4: carry rippling through every limb
        hwrite(6, {WIDE_W{1'b1}});
        hwrite(7, {{(WIDE_W-1){1'b0}}, 1'b1});
        issue(8'd0, 6, 7, 3, "R4 add full carry");
        verify_word("R4 add wrap dest", 3);

        // R5: borrow cases
        issue(8'd1, 7, 6, 4, "R5 sub borrow");
        verify_word("R5 sub borrow dest", 4);
        issue(8'd1, 6, 7, 5, "R5 sub no borrow");
        verify_word("R5 sub no borrow dest", 5);
        issue(8'd1, 2, 2, 1, "R5 sub equal");
        verify_word("R5 sub equal dest", 1);

        // R9: destination aliases a source
        hwrite(1, rnd_wide());
        issue(8'd0, 0, 1, 0, "R9 alias add");
        verify_word("R9 alias dest", 0);
        issue(8'd1, 3, 0, 3, "R9 alias sub");
        verify_word("R9 alias sub dest", 3);

        // R6: unsupported opcode leaves memory alone
        issue(8'h5a, 1, 2, 3, "R6 unsupported");
        verify_word("R6 dest untouched", 3);

        // R8: second start while busy is ignored
        @(negedge clk);
        ci_start = 1'b1;
        ci_n = 8'd0;
        ci_dataa = {16'd1, 16'd0};
        ci_datab = 32'd6;
        begin
            exp_t e;
            logic [WIDE_W:0] t;
            t = {1'b0, model[0]} + {1'b0, model[1]};
            e.tag = "R8 first op";
            e.res = {31'd0, t[WIDE_W]};
            e.due = cyc + 1 + 4;
            model[6] = t[WIDE_W-1:0];
            sbq.push_back(e);
        end
        @(negedge clk);
        ci_start = 1'b0;
        @(negedge clk);
        ci_start = 1'b1;
        ci_n = 8'd1;
        ci_dataa = {16'd2, 16'd5};
        ci_datab = 32'd7;
        @(negedge clk);
        ci_start = 1'b0;
        repeat (8) @(negedge clk);
        verify_word("R8 first op dest", 6);
        verify_word("R8 ignored dest untouched", 7);

        check32("R8 scoreboard drained", 32'(sbq.size()), 32'd0);
        finished = 1'b1;
        summary();
    end

endmodule